// File: doc/BRIEF.md
# RGB to Luminance Converter

This block turns a stream of colour pixels into 8-bit grey values for an image pipeline. Each pixel carries a blue, a green and a red byte. The block weights them at about 0.11, 0.59 and 0.30, rounds the sum to the nearest integer and returns one byte. The frame-start and row-valid markers that come with each pixel are delayed along with the data, so the grey stream can drive the next pipeline stage directly.

There are two ways to feed it. In parallel mode, all three components arrive in one word on every cycle in which the row marker is high. In byte mode, the components arrive one at a time on the low byte lane, in the order blue, green, red. One conversion starts when the red byte is taken. A frame-start marker on an accepted byte always makes that byte the blue component, so the block realigns at every frame boundary.

Top module: `rgb2luma`

## Requirements
- R1: In parallel mode, in_bgr bits [7:0] hold blue, [15:8] hold green and [23:16] hold red. The grey output is (28*B + 151*G + 77*R + 128) >> 8, which is rounding to the nearest integer.
- R2: In parallel mode, each cycle with in_rsync high starts one conversion. out_rsync goes high for exactly that conversion two clock cycles later, and out_grey carries its result.
- R3: The result is limited to 255. An all-255 pixel gives 255 and an all-zero pixel gives 0.
- R4: out_fsync is high only together with out_rsync. It marks, two cycles later, a parallel-mode pixel that was accepted with in_fsync high.
- R5: While in_rsync is low, in_bgr and in_fsync are ignored. Two cycles later out_rsync is low and out_grey keeps its previous value.
- R6: In byte mode (byte_mode high), each cycle with in_rsync high takes one byte from in_bgr[7:0]. The bytes are collected as blue, green, red. The conversion starts on the red byte, and its result appears with out_rsync two cycles later. The byte counter is cleared while byte_mode is low, so byte mode always starts at blue.
- R7: In byte mode, a byte taken with in_fsync high is always the blue component, whatever part of a pixel had already been collected. That pixel's result is marked with out_fsync.
- R8: In byte mode, cycles with in_rsync low add nothing to the collection. A pixel spread across gaps converts exactly as if its bytes had been consecutive.
- R9: While rst_n is low, out_rsync, out_fsync and out_grey are all 0.
- R10: A pixel whose three components are equal converts to that same value, because the weights sum to 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1: byte-serial input on in_bgr[7:0]; 0: one whole pixel per word |
| in_fsync | input | 1 | Frame-start marker on the current pixel or byte |
| in_rsync | input | 1 | Row marker; qualifies in_bgr |
| in_bgr | input | 24 | Colour input: blue [7:0], green [15:8], red [23:16] |
| out_fsync | output | 1 | Frame-start marker aligned with out_grey |
| out_rsync | output | 1 | High when out_grey holds a new result |
| out_grey | output | 8 | Grey value |

## Verification
The assertions assume that in_rsync, in_fsync and byte_mode are stable around each clock edge. They also assume that in_fsync only carries meaning when in_rsync is high, and that all inputs are held low during reset. The latency properties look two cycles back, so they rely on that quiet reset. The bench drives every input on the falling edge and keeps them at zero throughout reset. It changes byte_mode only after idle cycles. Its random frame-start pulses may fall on cycles with in_rsync low, where the requirements say they have no effect.

// File: rtl/luma_pkg.sv
package luma_pkg;
    localparam int PIX_W  = 8;
    localparam int NCH    = 3;
    localparam int COEF_W = 9;
    localparam int FRAC_W = 8;
    localparam int PROD_W = PIX_W + COEF_W;
    localparam int SUM_W  = PROD_W + $clog2(NCH) + 1;
    localparam int BUS_W  = PIX_W * NCH;

    typedef logic [PIX_W-1:0] pix_t;

    // channel 0 = blue, 1 = green, 2 = red
    typedef struct packed {
        logic                 go;
        logic                 fs;
        pix_t [NCH-1:0]       ch;
    } conv_req_t;
endpackage

// File: rtl/luma_gather.sv
module luma_gather
    import luma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_mode,
    input  logic             in_fsync,
    input  logic             in_rsync,
    input  logic [BUS_W-1:0] in_bgr,
    output conv_req_t        req
);
    localparam int              CNT_W = $clog2(NCH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NCH - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fs;
        pix_t [NCH-2:0]   held;
    } gat_state_t;

    gat_state_t st_d, st_q;
    pix_t       lane;

    assign lane = in_bgr[PIX_W-1:0];

    always_comb begin
        st_d = st_q;
        req  = '0;
        if (!byte_mode) begin
            st_d.cnt = '0;
            req.go   = in_rsync;
            req.fs   = in_fsync & in_rsync;
            for (int k = 0; k < NCH; k++) begin
                req.ch[k] = in_bgr[k*PIX_W +: PIX_W];
            end
        end else if (in_rsync) begin
            if (in_fsync) begin
                st_d.held[0] = lane;
                st_d.fs      = 1'b1;
                st_d.cnt     = CNT_W'(1);
            end else if (st_q.cnt == LAST) begin
                req.go = 1'b1;
                req.fs = st_q.fs;
                for (int k = 0; k < NCH-1; k++) begin
                    req.ch[k] = st_q.held[k];
                end
                req.ch[NCH-1] = lane;
                st_d.cnt      = '0;
            end else begin
                for (int k = 0; k < NCH-1; k++) begin
                    if (st_q.cnt == CNT_W'(k)) begin
                        st_d.held[k] = lane;
                    end
                end
                if (st_q.cnt == '0) begin
                    st_d.fs = 1'b0;
                end
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R6

    AST_FSYNC_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && in_rsync && in_fsync) |=> (st_q.cnt == CNT_W'(1) && st_q.fs)); // R7

    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && !in_rsync) |=> $stable(st_q.cnt)); // R8
endmodule

// File: rtl/luma_mac.sv
module luma_mac
    import luma_pkg::*;
#(
    parameter int W_BLU = 28,
    parameter int W_GRN = 151,
    parameter int W_RED = 77
) (
    input  logic      clk,
    input  logic      rst_n,
    input  conv_req_t req,
    output logic      out_fsync,
    output logic      out_rsync,
    output pix_t      out_grey
);
    localparam int               WSUM    = W_BLU + W_GRN + W_RED;
    localparam int               WGT [NCH] = '{W_BLU, W_GRN, W_RED};
    localparam logic [SUM_W-1:0] HALF    = SUM_W'(1) << (FRAC_W - 1);
    localparam logic [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

    typedef struct packed {
        logic                         v;
        logic                         fs;
        logic [NCH-1:0][PROD_W-1:0]   prod;
    } mul_stage_t;

    typedef struct packed {
        logic v;
        logic fs;
        pix_t grey;
    } out_stage_t;

    typedef struct packed {
        mul_stage_t m;
        out_stage_t o;
    } mac_state_t;

    mac_state_t                 st_d, st_q;
    logic [NCH-1:0][PROD_W-1:0] prod_c;
    logic [SUM_W-1:0]           acc_c;
    logic [SUM_W-1:0]           scaled_c;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_mul
            assign prod_c[i] = PROD_W'(req.ch[i]) * PROD_W'(WGT[i]);
        end
    endgenerate

    always_comb begin
        acc_c = HALF;
        for (int k = 0; k < NCH; k++) begin
            acc_c = acc_c + SUM_W'(st_q.m.prod[k]);
        end
        scaled_c = acc_c >> FRAC_W;
    end

    always_comb begin
        st_d      = st_q;
        st_d.m.v  = req.go;
        st_d.m.fs = req.go & req.fs;
        if (req.go) begin
            st_d.m.prod = prod_c;
        end
        st_d.o.v  = st_q.m.v;
        st_d.o.fs = st_q.m.fs;
        if (st_q.m.v) begin
            st_d.o.grey = (scaled_c > PIX_MAX) ? '1 : scaled_c[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_rsync = st_q.o.v;
    assign out_fsync = st_q.o.fs;
    assign out_grey  = st_q.o.grey;

    generate
        if (WSUM <= (1 << FRAC_W)) begin : g_ovf
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.m.v |-> (scaled_c <= PIX_MAX)); // R3
        end
    endgenerate

    AST_GREY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.m.v |=> $stable(out_grey)); // R5
endmodule

// File: rtl/rgb2luma.sv
module rgb2luma
    import luma_pkg::*;
#(
    parameter int W_BLU = 28,
    parameter int W_GRN = 151,
    parameter int W_RED = 77
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_mode,
    input  logic             in_fsync,
    input  logic             in_rsync,
    input  logic [BUS_W-1:0] in_bgr,
    output logic             out_fsync,
    output logic             out_rsync,
    output logic [PIX_W-1:0] out_grey
);
    conv_req_t req;

    luma_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .in_fsync  (in_fsync),
        .in_rsync  (in_rsync),
        .in_bgr    (in_bgr),
        .req       (req)
    );

    luma_mac #(
        .W_BLU (W_BLU),
        .W_GRN (W_GRN),
        .W_RED (W_RED)
    ) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .out_fsync (out_fsync),
        .out_rsync (out_rsync),
        .out_grey  (out_grey)
    );

    AST_LAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        req.go |=> ##1 out_rsync); // R2

    AST_LAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        !req.go |=> ##1 !out_rsync); // R5

    AST_FS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        out_fsync |-> out_rsync); // R4
endmodule

// File: tb/rgb2luma_tb.sv
`timescale 1ns/1ps
module rgb2luma_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        byte_mode;
    logic        in_fsync;
    logic        in_rsync;
    logic [23:0] in_bgr;
    logic        out_fsync;
    logic        out_rsync;
    logic [7:0]  out_grey;

    always #10 clk = ~clk;

    rgb2luma u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .in_fsync  (in_fsync),
        .in_rsync  (in_rsync),
        .in_bgr    (in_bgr),
        .out_fsync (out_fsync),
        .out_rsync (out_rsync),
        .out_grey  (out_grey)
    );

    typedef struct {
        bit v;
        bit f;
        bit m;
        int g;
    } ev_t;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    ev_t   d1, d2;
    int    m_cnt, m_b, m_g;
    bit    m_fs;
    int    last_grey;
    string ph_tag;

    function automatic int grey_of(int b, int g, int r);
        int s;
        s = (28*b + 151*g + 77*r + 128) >> 8;
        if (s > 255) s = 255;
        return s;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rbyte();
        int k;
        k = $urandom % 8;
        if (k == 0) return 0;
        if (k == 1) return 255;
        return $urandom % 256;
    endfunction

    task automatic step(bit rs, bit fs, logic [23:0] d);
        ev_t e;
        @(negedge clk);
        chk(d2.m ? (d2.v ? "R6" : "R8") : (d2.v ? "R2" : "R5"), int'(out_rsync), int'(d2.v));
        if (d2.v) begin
            chk(ph_tag, int'(out_grey), d2.g);
            chk(d2.m ? "R7" : "R4", int'(out_fsync), int'(d2.f));
            last_grey = d2.g;
        end else begin
            chk("R5", int'(out_grey), last_grey);
            chk("R4", int'(out_fsync), 0);
        end
        d2 = d1;
        in_rsync = rs;
        in_fsync = fs;
        in_bgr   = d;
        e = '{v: 1'b0, f: 1'b0, m: byte_mode, g: 0};
        if (!byte_mode) begin
            m_cnt = 0;
            if (rs) begin
                e.v = 1'b1;
                e.f = fs;
                e.g = grey_of(int'(d[7:0]), int'(d[15:8]), int'(d[23:16]));
            end
        end else if (rs) begin
            if (fs) begin
                m_b = int'(d[7:0]); m_fs = 1'b1; m_cnt = 1;
            end else if (m_cnt == 0) begin
                m_b = int'(d[7:0]); m_fs = 1'b0; m_cnt = 1;
            end else if (m_cnt == 1) begin
                m_g = int'(d[7:0]); m_cnt = 2;
            end else begin
                e.v = 1'b1;
                e.f = m_fs;
                e.g = grey_of(m_b, m_g, int'(d[7:0]));
                m_cnt = 0;
            end
        end
        d1 = e;
    endtask

    task automatic pix(int b, int g, int r, bit fs);
        step(1'b1, fs, {r[7:0], g[7:0], b[7:0]});
    endtask

    task automatic bytes3(int b, int g, int r, bit fs);
        step(1'b1, fs, {16'h0, b[7:0]});
        step(1'b1, 1'b0, {16'h0, g[7:0]});
        step(1'b1, 1'b0, {16'h0, r[7:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        d1 = '{v: 1'b0, f: 1'b0, m: 1'b0, g: 0};
        d2 = d1;
        m_cnt = 0; m_b = 0; m_g = 0; m_fs = 1'b0; last_grey = 0;
        rst_n = 1'b0; byte_mode = 1'b0; in_fsync = 1'b0; in_rsync = 1'b0; in_bgr = '0;
        repeat (3) @(negedge clk);
        chk("R9", int'(out_rsync), 0);
        chk("R9", int'(out_fsync), 0);
        chk("R9", int'(out_grey), 0);
        rst_n = 1'b1;

        // directed parallel cases
        ph_tag = "R3"; pix(0, 0, 0, 1'b1); pix(255, 255, 255, 1'b0);
        ph_tag = "R1"; pix(0, 0, 1, 1'b0); pix(0, 0, 2, 1'b0); pix(0, 0, 255, 1'b0);
        pix(255, 0, 0, 1'b0); pix(0, 255, 0, 1'b0); pix(10, 200, 90, 1'b1);
        ph_tag = "R10"; pix(100, 100, 100, 1'b0); pix(37, 37, 37, 1'b0); pix(1, 1, 1, 1'b0);
        ph_tag = "R5"; step(1'b0, 1'b1, 24'hffffff); step(1'b0, 1'b0, 24'h123456);
        ph_tag = "R1";
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 4) != 0, ($urandom % 12) == 0,
                 {rbyte()[7:0], rbyte()[7:0], rbyte()[7:0]});
        end
        repeat (3) step(1'b0, 1'b0, 24'h0);

        // byte-serial mode
        byte_mode = 1'b1;
        ph_tag = "R6";
        repeat (2) step(1'b0, 1'b0, 24'h0);
        bytes3(10, 200, 90, 1'b1);
        bytes3(255, 255, 255, 1'b0);
        ph_tag = "R8";
        step(1'b1, 1'b0, 24'h000040);
        step(1'b0, 1'b0, 24'h0000ff);
        step(1'b1, 1'b0, 24'h000080);
        step(1'b0, 1'b1, 24'h000011);
        step(1'b1, 1'b0, 24'h0000c0);
        ph_tag = "R7";
        step(1'b1, 1'b0, 24'h000005);
        bytes3(60, 70, 80, 1'b1);
        step(1'b1, 1'b0, 24'h000005);
        step(1'b1, 1'b0, 24'h000006);
        bytes3(9, 8, 7, 1'b1);
        ph_tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, ($urandom % 20) == 0, {16'h0, rbyte()[7:0]});
        end
        repeat (3) step(1'b0, 1'b0, 24'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule